// File: doc/BRIEF.md
# Nibble-Indexed Status Register with General Register File

This block holds a 16-bit processor status word next to a file of sixteen 16-bit general registers. The low byte of the status word carries special-purpose state: four arithmetic flags and four memory-routing flags. The high byte is free for software and serves three uses at once. Its two nibbles are small index registers that name general registers. Read as a whole, the byte is an unsigned stack offset that can be stepped up or down by one.

The instruction decoder presents a 3-bit operand-select code. The block answers in the same cycle with the number of the chosen general register and that register's value. The value can serve as a data operand or as a memory address. Some codes pick the index nibble outright. The others let the live value of one arithmetic flag choose between the two nibbles, which gives flag-conditional register indexing with no branch.

Flags are loaded from an ALU result, and software can write the status word through several direct-write kinds. Two of the routing flags tell the memory side whether a transfer's source and destination lie in the code page or in the data page.

Top module: `nibsel_status_unit`

## Requirements
- R1: After reset the status word, the stack offset and both page selects read 0, and every general register reads 0.
- R2: When `alu_en` is 1, the next status has bit 0 = 1 exactly when `alu_res` is zero, bit 1 = `alu_res[15]`, bit 2 = `alu_cry` and bit 3 = `alu_res[0]`. Bits 15:4 do not change.
- R3: When `wr_en` is 1, `wr_kind` chooses what is written: 0 loads all 16 bits, 1 loads bits 15:8, 2 loads only the X nibble (bits 11:8) and 3 loads only the Y nibble (bits 15:12). Each kind takes its data from the same bit positions of `wr_data`, and all other bits keep their value.
- R4: A full-word write (kind 0) in the same cycle as an ALU update wins on every bit. A byte or nibble write in the same cycle as an ALU update applies both changes.
- R5: `step_inc` alone adds 1 to bits 15:8 modulo 256. `step_dec` alone subtracts 1 modulo 256. Both together, or a step in a cycle that has `wr_en`, leave bits 15:8 unchanged.
- R6: When `rf_we` is 1, `rf_wdata` is stored into general register `rf_waddr` at the clock edge. No other register changes.
- R7: With `op_sel` 0 the chosen register number is the X nibble, and with `op_sel` 1 it is the Y nibble. `sel_num` gives that number and `sel_val` gives its register's current value, both in the same cycle.
- R8: `op_sel` 2, 3, 4 and 5 test the zero, negative, carry and parity flag respectively. A flag of 1 chooses the X nibble and a flag of 0 chooses the Y nibble. Codes 6 and 7 act like code 0.
- R9: `src_page` reports status bit 4 and `dst_page` reports bit 5 (0 means the code page, 1 means the data page). Bits 7:6 read back as last written, and `stack_ofs` reports bits 15:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_en | input | 1 | Load the arithmetic flags from the ALU result |
| alu_res | input | 16 | ALU result word |
| alu_cry | input | 1 | ALU carry out |
| wr_en | input | 1 | Direct write to the status word |
| wr_kind | input | 2 | 0 full word, 1 high byte, 2 X nibble, 3 Y nibble |
| wr_data | input | 16 | Write data, aligned to status bit positions |
| step_inc | input | 1 | Increment the stack offset |
| step_dec | input | 1 | Decrement the stack offset |
| rf_we | input | 1 | General register write enable |
| rf_waddr | input | 4 | General register write index |
| rf_wdata | input | 16 | General register write data |
| op_sel | input | 3 | Operand-select code |
| sel_num | output | 4 | Number of the chosen register |
| sel_val | output | 16 | Value of the chosen register |
| status_o | output | 16 | Current status word |
| stack_ofs | output | 8 | Stack offset (high byte) |
| src_page | output | 1 | Source page select |
| dst_page | output | 1 | Destination page select |

## Verification
The bench walks all sixteen flag combinations against every operand-select code. A design that reversed the X/Y polarity, or wired a code to the wrong flag, would return the other register's number and value. The offset is stepped across 255→0 and back, so a design that saturates or carries into the flag byte shows the wrong offset. Same-cycle conflicts are driven on purpose: a full write against an ALU update, a byte write against an ALU update, and a step against a direct write. A design that let the ALU win, dropped one of two compatible updates, or stepped over a fresh write would show a wrong status word. Nibble writes are checked with the other nibble holding a different value, which exposes a write that clobbers the whole byte.

// File: rtl/nibsel_pkg.sv
`timescale 1ns/1ps
package nibsel_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;

  typedef struct packed {
    logic [NIB_W-1:0] by;
    logic [NIB_W-1:0] bx;
    logic [1:0]       rsv;
    logic             dst_pg;
    logic             src_pg;
    logic             par;
    logic             cry;
    logic             neg;
    logic             zro;
  } status_t;

  typedef enum logic [2:0] {
    SEL_X  = 3'd0,
    SEL_Y  = 3'd1,
    SEL_Z  = 3'd2,
    SEL_N  = 3'd3,
    SEL_C  = 3'd4,
    SEL_P  = 3'd5,
    SEL_R6 = 3'd6,
    SEL_R7 = 3'd7
  } opsel_e;

  typedef enum logic [1:0] {
    WR_FULL = 2'd0,
    WR_GEN  = 2'd1,
    WR_BX   = 2'd2,
    WR_BY   = 2'd3
  } wrkind_e;
endpackage

// File: rtl/nibsel_rst_sync.sv
`timescale 1ns/1ps
module nibsel_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ln
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ln = sync_q[STAGES-1];
endmodule

// File: rtl/nibsel_status_next.sv
`timescale 1ns/1ps
module nibsel_status_next
  import nibsel_pkg::*;
(
  input  status_t            cur,
  input  logic               alu_en,
  input  logic [WORD_W-1:0]  alu_res,
  input  logic               alu_cry,
  input  logic               wr_en,
  input  wrkind_e            wr_kind,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic               step_inc,
  input  logic               step_dec,
  output status_t            nxt,
  output logic               load
);
  status_t           wr_word;
  logic              step_one;
  logic [BYTE_W-1:0] gen_cur;
  logic [BYTE_W-1:0] gen_step;

  assign wr_word  = status_t'(wr_data);
  assign step_one = step_inc ^ step_dec;
  assign gen_cur  = {cur.by, cur.bx};
  assign gen_step = step_inc ? gen_cur + BYTE_W'(1) : gen_cur - BYTE_W'(1);
  assign load     = alu_en | wr_en | step_one;

  always_comb begin
    nxt = cur;
    if (alu_en) begin
      nxt.zro = (alu_res == '0);
      nxt.neg = alu_res[WORD_W-1];
      nxt.cry = alu_cry;
      nxt.par = alu_res[0];
    end
    if (wr_en) begin
      unique case (wr_kind)
        WR_FULL: nxt = wr_word;
        WR_GEN:  begin nxt.by = wr_word.by; nxt.bx = wr_word.bx; end
        WR_BX:   nxt.bx = wr_word.bx;
        WR_BY:   nxt.by = wr_word.by;
        default: nxt = cur;
      endcase
    end else if (step_one) begin
      {nxt.by, nxt.bx} = gen_step;
    end
  end
endmodule

// File: rtl/nibsel_regfile.sv
`timescale 1ns/1ps
module nibsel_regfile #(
  parameter int REG_W    = 16,
  parameter int IDX_W    = 4,
  localparam int NUM_REGS = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_ln,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [REG_W-1:0] wdata,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [REG_W-1:0] rd_data
);
  logic [REG_W-1:0] regs_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic             wen;
    logic [REG_W-1:0] q;

    assign wen = we && (waddr == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_ln) begin
      if (!rst_ln)  q <= '0;
      else if (wen) q <= wdata;
    end

    assign regs_q[i] = q;
  end

  assign rd_data = regs_q[rd_idx];
endmodule

// File: rtl/nibsel_opsel.sv
`timescale 1ns/1ps
module nibsel_opsel
  import nibsel_pkg::*;
(
  input  status_t          st,
  input  opsel_e           op,
  output logic [NIB_W-1:0] idx
);
  logic use_x;

  always_comb begin
    unique case (op)
      SEL_X:   use_x = 1'b1;
      SEL_Y:   use_x = 1'b0;
      SEL_Z:   use_x = st.zro;
      SEL_N:   use_x = st.neg;
      SEL_C:   use_x = st.cry;
      SEL_P:   use_x = st.par;
      default: use_x = 1'b1;
    endcase
  end

  assign idx = use_x ? st.bx : st.by;
endmodule

// File: rtl/nibsel_status_unit.sv
`timescale 1ns/1ps
module nibsel_status_unit
  import nibsel_pkg::*;
#(
  parameter int REG_W = 16,
  localparam int IDX_W = NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alu_en,
  input  logic [WORD_W-1:0] alu_res,
  input  logic              alu_cry,
  input  logic              wr_en,
  input  logic [1:0]        wr_kind,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              step_inc,
  input  logic              step_dec,
  input  logic              rf_we,
  input  logic [IDX_W-1:0]  rf_waddr,
  input  logic [REG_W-1:0]  rf_wdata,
  input  logic [2:0]        op_sel,
  output logic [IDX_W-1:0]  sel_num,
  output logic [REG_W-1:0]  sel_val,
  output logic [WORD_W-1:0] status_o,
  output logic [BYTE_W-1:0] stack_ofs,
  output logic              src_page,
  output logic              dst_page
);
  logic    rst_ln;
  status_t stat_q;
  status_t stat_d;
  logic    stat_ld;

  nibsel_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ln (rst_ln)
  );

  nibsel_status_next u_next (
    .cur      (stat_q),
    .alu_en   (alu_en),
    .alu_res  (alu_res),
    .alu_cry  (alu_cry),
    .wr_en    (wr_en),
    .wr_kind  (wrkind_e'(wr_kind)),
    .wr_data  (wr_data),
    .step_inc (step_inc),
    .step_dec (step_dec),
    .nxt      (stat_d),
    .load     (stat_ld)
  );

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln)      stat_q <= '0;
    else if (stat_ld) stat_q <= stat_d;
  end

  nibsel_opsel u_opsel (
    .st  (stat_q),
    .op  (opsel_e'(op_sel)),
    .idx (sel_num)
  );

  nibsel_regfile #(.REG_W(REG_W), .IDX_W(IDX_W)) u_rf (
    .clk     (clk),
    .rst_ln  (rst_ln),
    .we      (rf_we),
    .waddr   (rf_waddr),
    .wdata   (rf_wdata),
    .rd_idx  (sel_num),
    .rd_data (sel_val)
  );

  assign status_o  = stat_q;
  assign stack_ofs = {stat_q.by, stat_q.bx};
  assign src_page  = stat_q.src_pg;
  assign dst_page  = stat_q.dst_pg;
endmodule

// File: rtl/nibsel_status_chk.sv
`timescale 1ns/1ps
module nibsel_status_chk
  import nibsel_pkg::*;
(
  input logic              clk,
  input logic              rst_ln,
  input logic              alu_en,
  input logic [WORD_W-1:0] alu_res,
  input logic              wr_en,
  input logic [1:0]        wr_kind,
  input logic [WORD_W-1:0] wr_data,
  input logic              step_inc,
  input logic              step_dec,
  input logic [2:0]        op_sel,
  input logic [NIB_W-1:0]  sel_num,
  input logic [WORD_W-1:0] status_o,
  input logic [BYTE_W-1:0] stack_ofs
);
  // R2
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    (alu_en && !(wr_en && wr_kind == WR_FULL)) |=> status_o[0] == ($past(alu_res) == '0));

  // R3
  bx_keeps_by_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    (wr_en && wr_kind == WR_BX) |=>
      (status_o[15:12] == $past(status_o[15:12]) && status_o[11:8] == $past(wr_data[11:8])));

  // R4
  full_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    (wr_en && wr_kind == WR_FULL) |=> status_o == $past(wr_data));

  // R5
  ofs_inc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    (step_inc && !step_dec && !wr_en) |=> stack_ofs == $past(stack_ofs) + 8'd1);

  // R5
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    (!alu_en && !wr_en && (step_inc == step_dec)) |=> $stable(status_o));

  // R8
  zero_cond_sel_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    (op_sel == SEL_Z) |-> sel_num == (status_o[0] ? status_o[11:8] : status_o[15:12]));
endmodule

bind nibsel_status_unit nibsel_status_chk u_chk (
  .clk       (clk),
  .rst_ln    (rst_ln),
  .alu_en    (alu_en),
  .alu_res   (alu_res),
  .wr_en     (wr_en),
  .wr_kind   (wr_kind),
  .wr_data   (wr_data),
  .step_inc  (step_inc),
  .step_dec  (step_dec),
  .op_sel    (op_sel),
  .sel_num   (sel_num),
  .status_o  (status_o),
  .stack_ofs (stack_ofs)
);

// File: tb/nibsel_status_unit_test.sv
`timescale 1ns/1ps
module nibsel_status_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        alu_en, alu_cry, wr_en, step_inc, step_dec, rf_we;
  logic [15:0] alu_res, wr_data, rf_wdata;
  logic [1:0]  wr_kind;
  logic [3:0]  rf_waddr;
  logic [2:0]  op_sel;
  logic [3:0]  sel_num;
  logic [15:0] sel_val, status_o;
  logic [7:0]  stack_ofs;
  logic        src_page, dst_page;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  nibsel_status_unit uut (
    .clk(clk), .rst_n(rst_n), .alu_en(alu_en), .alu_res(alu_res), .alu_cry(alu_cry),
    .wr_en(wr_en), .wr_kind(wr_kind), .wr_data(wr_data), .step_inc(step_inc),
    .step_dec(step_dec), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .op_sel(op_sel), .sel_num(sel_num), .sel_val(sel_val), .status_o(status_o),
    .stack_ofs(stack_ofs), .src_page(src_page), .dst_page(dst_page)
  );

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] reg_pat(input int i);
    return 16'hA000 + 16'(i) * 16'h0111;
  endfunction

  task automatic do_write(input logic [1:0] kind, input logic [15:0] data);
    wr_en = 1'b1; wr_kind = kind; wr_data = data;
    tick;
    wr_en = 1'b0;
  endtask

  task automatic do_alu(input logic [15:0] res, input logic cy);
    alu_en = 1'b1; alu_res = res; alu_cry = cy;
    tick;
    alu_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 status", status_o, 16'h0000);
    chk("R1 stack", {8'h0, stack_ofs}, 16'h0000);
    chk("R1 pages", {14'h0, dst_page, src_page}, 16'h0000);
    op_sel = 3'd0; #0.5;
    chk("R1 reg0", sel_val, 16'h0000);
  endtask

  task automatic t_regfile;
    for (int i = 0; i < 16; i++) begin
      rf_we = 1'b1; rf_waddr = 4'(i); rf_wdata = reg_pat(i);
      tick;
    end
    rf_we = 1'b0;
    for (int i = 0; i < 16; i++) begin
      do_write(2'd1, {4'(15 - i), 4'(i), 8'h00});
      op_sel = 3'd0; #0.5;
      chk("R7 Rx num", {12'h0, sel_num}, 16'(i));
      chk("R6 Rx val", sel_val, reg_pat(i));
      op_sel = 3'd1; #0.5;
      chk("R7 Ry num", {12'h0, sel_num}, 16'(15 - i));
      chk("R6 Ry val", sel_val, reg_pat(15 - i));
    end
  endtask

  task automatic t_alu;
    do_write(2'd0, 16'h5AF0);
    do_alu(16'h0000, 1'b1);
    chk("R2 zero+carry", status_o, 16'h5AF5);
    do_alu(16'h8001, 1'b0);
    chk("R2 neg+parity", status_o, 16'h5AFA);
    do_alu(16'h0002, 1'b0);
    chk("R2 clear", status_o, 16'h5AF0);
  endtask

  task automatic t_writes;
    do_write(2'd0, 16'h3C71);
    chk("R3 full", status_o, 16'h3C71);
    do_write(2'd1, 16'h5A00);
    chk("R3 byte", status_o, 16'h5A71);
    do_write(2'd2, 16'hFF00);
    chk("R3 X nibble", status_o, 16'h5F71);
    do_write(2'd3, 16'h1200);
    chk("R3 Y nibble", status_o, 16'h1F71);
    do_write(2'd0, 16'h00D0);
    chk("R9 reserved", status_o, 16'h00D0);
    chk("R9 src", {15'h0, src_page}, 16'h1);
    chk("R9 dst", {15'h0, dst_page}, 16'h0);
    do_write(2'd0, 16'h4C20);
    chk("R9 src2", {15'h0, src_page}, 16'h0);
    chk("R9 dst2", {15'h0, dst_page}, 16'h1);
    chk("R9 stack", {8'h0, stack_ofs}, 16'h004C);
  endtask

  task automatic t_conflict;
    alu_en = 1'b1; alu_res = 16'h0000; alu_cry = 1'b1;
    do_write(2'd0, 16'h0000);
    alu_en = 1'b0;
    chk("R4 full wins", status_o, 16'h0000);
    alu_en = 1'b1; alu_res = 16'hFFFF; alu_cry = 1'b1;
    do_write(2'd1, 16'h7700);
    alu_en = 1'b0;
    chk("R4 byte+alu", status_o, 16'h770E);
  endtask

  task automatic t_step;
    do_write(2'd0, 16'hFF05);
    step_inc = 1'b1; tick; step_inc = 1'b0;
    chk("R5 inc wrap", status_o, 16'h0005);
    step_dec = 1'b1; tick;
    chk("R5 dec wrap", status_o, 16'hFF05);
    tick; step_dec = 1'b0;
    chk("R5 dec", {8'h0, stack_ofs}, 16'h00FE);
    step_inc = 1'b1; step_dec = 1'b1; tick;
    chk("R5 both", status_o, 16'hFE05);
    step_dec = 1'b0;
    do_write(2'd1, 16'h1000);
    step_inc = 1'b0;
    chk("R5 write wins", status_o, 16'h1005);
  endtask

  task automatic t_cond;
    for (int f = 0; f < 16; f++) begin
      do_write(2'd0, {8'h93, 4'h0, 4'(f)});
      for (int c = 0; c < 8; c++) begin
        logic use_x;
        logic [3:0] n;
        case (c)
          1:       use_x = 1'b0;
          2:       use_x = f[0];
          3:       use_x = f[1];
          4:       use_x = f[2];
          5:       use_x = f[3];
          default: use_x = 1'b1;
        endcase
        n = use_x ? 4'h3 : 4'h9;
        op_sel = 3'(c); #0.25;
        chk("R8 num", {12'h0, sel_num}, {12'h0, n});
        chk("R8 val", sel_val, reg_pat(int'(n)));
      end
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(4 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary;
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    alu_en = 0; alu_cry = 0; wr_en = 0; step_inc = 0; step_dec = 0; rf_we = 0;
    alu_res = '0; wr_data = '0; rf_wdata = '0; wr_kind = '0; rf_waddr = '0; op_sel = '0;
    repeat (3) tick;
    rst_n = 1'b1;
    repeat (4) tick;
    t_reset;
    t_regfile;
    t_alu;
    t_writes;
    t_conflict;
    t_step;
    t_cond;
    summary;
    $finish;
  end
endmodule